// File: doc/BRIEF.md
# Dual-Channel FIFO Bus-Master Sequencer

This block runs two DMA-style transfer channels through one shared 8-entry, 32-bit FIFO that sits between a local transfer-buffer port and a burst-capable system bus. Each channel is loaded with a direction and a length in 32-bit words. A write moves data from the local side to the bus, and a read moves data the other way. The sequencer only claims the bus for full bursts. A write starts its bus cycle once the FIFO is full. A read starts its bus cycle only when the FIFO is empty.

A segment can end early in two ways. If the FIFO empties during a write, or fills during a read, the burst is dropped but the bus request stays asserted. If a page-break or abort event arrives, the FIFO is flushed and the segment restarts later. In both cases the sequencer re-arbitrates and prefers the channel that did not just run. For writes, the local side prefetches until the FIFO is full, so up to 7 words (28 bytes) past the transfer end may be loaded. Those surplus words are discarded when the transfer finishes. At that point a one-cycle end-of-transfer pulse is driven and a sticky per-channel done flag is set.

Top module: `dma_seq_top`

## Requirements
- R1: After reset, trq_o, breq_o, bstart_o, bburst_o, teop_o and done_o are 0, and fifo_level_o is 0.
- R2: For a write (ld_wr_i=1), trq_o is high while the FIFO fills, and each tack_i pushes tdat_i. trq_o drops in the cycle after the push that makes the level 8. The bus is not requested before that point.
- R3: While waiting for the bus, breq_o is high. bstart_o is high only in a cycle where bgnt_i is high, and bburst_o is high from the next cycle.
- R4: The bus strobe that moves a channel's last word is followed, on the next edge, by teop_o high for exactly one cycle. The same edge sets that channel's done_o bit (bit 0 = channel 0) and empties the FIFO, discarding any prefetched surplus.
- R5: For a read (ld_wr_i=0), the bus cycle starts only with the FIFO empty. The burst carries min(remaining, 8) words, after which bburst_o drops and trq_o rises so the local side can drain through tack_i.
- R6: If a read has more than 8 words left when the FIFO fills, breq_o stays high. trq_o stays high until the FIFO is completely empty, then goes low.
- R7: If a write empties the FIFO with words still to move, bburst_o drops, breq_o stays high, and no new start is issued until the FIFO is full again.
- R8: At a stall or obstacle, if the other channel has a pending transfer, it is selected next (cur_ch_o).
- R9: obst_i during a burst ends the burst, flushes the FIFO and keeps the channel's remaining count, so the whole segment is moved again later.
- R10: A load aimed at a busy channel, or a load of length 0, has no effect.
- R11: done_clr_i[n] clears done_o[n].
- R12: Words leave the FIFO in the order they entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 1 | Load a channel |
| ld_chan_i | input | 1 | Channel to load |
| ld_wr_i | input | 1 | 1 = write toward bus, 0 = read from bus |
| ld_words_i | input | CW | Transfer length in 32-bit words |
| done_clr_i | input | 2 | Per-channel done clear |
| trq_o | output | 1 | Local transfer request |
| tack_i | input | 1 | Local word acknowledge |
| tdat_i | input | DW | Local write data |
| tdat_o | output | DW | Local read data (FIFO head) |
| teop_o | output | 1 | End-of-transfer pulse |
| breq_o | output | 1 | Bus request |
| bgnt_i | input | 1 | Bus grant |
| bstart_o | output | 1 | Bus cycle start |
| bburst_o | output | 1 | Burst enable |
| bstrb_i | input | 1 | Bus data strobe |
| bdat_i | input | DW | Bus read data |
| bdat_o | output | DW | Bus write data (FIFO head) |
| obst_i | input | 1 | Page break / abort event |
| cur_ch_o | output | 1 | Channel currently selected |
| done_o | output | 2 | Per-channel done flags |
| fifo_level_o | output | LW | FIFO fill level |

## Verification
A load is registered on one edge, and the idle state picks the channel on the next edge. trq_o or breq_o is therefore due two edges after the load is applied. bstart_o is combinational on bgnt_i while the sequencer waits, so it is checked before the edge, and bburst_o is checked after it. Every push, pop, level change and stall or done transition appears right after the edge that sampled the strobe or acknowledge. teop_o and done_o appear after the edge of the final strobe. The bench drives all inputs and samples all outputs at the falling edge, one edge at a time, and compares each result against the cycle count worked out from these rules.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_FILL,
    S_REQ,
    S_BURST,
    S_DRAIN
  } seq_state_e;
endpackage

// File: rtl/dma_seq_fifo.sv
module dma_seq_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [LW-1:0] level_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] cnt;
  logic do_push, do_pop;

  assign do_push = push_i && (cnt != LW'(DEPTH));
  assign do_pop  = pop_i && (cnt != '0);
  assign rdata_o = mem[rptr];
  assign level_o = cnt;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem[wptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (flush_i) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= inc(wptr);
      if (do_pop)  rptr <= inc(rptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/dma_seq_chan.sv
module dma_seq_chan #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic          ld_wr_i,
  input  logic [CW-1:0] ld_words_i,
  input  logic          dec_i,
  input  logic          fin_i,
  input  logic          clr_i,
  output logic          busy_o,
  output logic          wr_o,
  output logic [CW-1:0] rem_o,
  output logic          done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      wr_o   <= 1'b0;
      rem_o  <= '0;
      done_o <= 1'b0;
    end else begin
      if (fin_i) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end else begin
        if (clr_i) done_o <= 1'b0;
        // loads into a busy channel or of zero length are dropped
        if (ld_i && !busy_o && ld_words_i != '0) begin
          busy_o <= 1'b1;
          wr_o   <= ld_wr_i;
        end
      end
      if (ld_i && !busy_o && ld_words_i != '0) rem_o <= ld_words_i;
      else if (dec_i)                          rem_o <= rem_o - 1'b1;
    end
  end
endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top
  import dma_seq_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int CW    = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_valid_i,
  input  logic          ld_chan_i,
  input  logic          ld_wr_i,
  input  logic [CW-1:0] ld_words_i,
  input  logic [1:0]    done_clr_i,
  output logic          trq_o,
  input  logic          tack_i,
  input  logic [DW-1:0] tdat_i,
  output logic [DW-1:0] tdat_o,
  output logic          teop_o,
  output logic          breq_o,
  input  logic          bgnt_i,
  output logic          bstart_o,
  output logic          bburst_o,
  input  logic          bstrb_i,
  input  logic [DW-1:0] bdat_i,
  output logic [DW-1:0] bdat_o,
  input  logic          obst_i,
  output logic          cur_ch_o,
  output logic [1:0]    done_o,
  output logic [LW-1:0] fifo_level_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  seq_state_e st, nxt;
  logic          cur, pick, pick_en, hold, hold_set, teop_q;
  logic [LW-1:0] bcnt, level;
  logic [1:0]    busy_a, wr_a;
  logic [CW-1:0] rem_a [2];
  logic          cur_wr, push, pop, flush, fin;
  logic [CW-1:0] cur_rem;
  logic [DW-1:0] head;

  for (genvar g = 0; g < 2; g++) begin : g_chan
    dma_seq_chan #(.CW(CW)) i_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ld_i       (ld_valid_i && (ld_chan_i == 1'(g))),
      .ld_wr_i    (ld_wr_i),
      .ld_words_i (ld_words_i),
      .dec_i      (pop && (cur == 1'(g))),
      .fin_i      (fin && (cur == 1'(g))),
      .clr_i      (done_clr_i[g]),
      .busy_o     (busy_a[g]),
      .wr_o       (wr_a[g]),
      .rem_o      (rem_a[g]),
      .done_o     (done_o[g])
    );
  end

  assign cur_wr  = wr_a[cur];
  assign cur_rem = rem_a[cur];
  assign pick    = busy_a[~cur] ? ~cur : cur;
  assign fin     = pop && (cur_rem == CW'(1));

  dma_seq_fifo #(.DW(DW), .DEPTH(DEPTH)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (push),
    .wdata_i (cur_wr ? tdat_i : bdat_i),
    .pop_i   (pop),
    .rdata_o (head),
    .level_o (level)
  );

  always_comb begin
    nxt      = st;
    push     = 1'b0;
    pop      = 1'b0;
    flush    = 1'b0;
    hold_set = 1'b0;
    pick_en  = 1'b0;
    unique case (st)
      S_IDLE: if (busy_a[pick]) begin
        pick_en = 1'b1;
        nxt     = wr_a[pick] ? S_FILL : S_REQ;
      end
      S_FILL: begin
        push = tack_i;
        if (tack_i && level == LW'(DEPTH - 1)) nxt = S_REQ;
      end
      S_REQ: if (bgnt_i) nxt = S_BURST;
      S_BURST: begin
        if (obst_i) begin
          flush    = 1'b1;
          hold_set = 1'b1;
          nxt      = S_IDLE;
        end else if (cur_wr) begin
          pop = bstrb_i;
          if (bstrb_i && cur_rem == CW'(1)) begin
            flush = 1'b1;            // drop prefetched surplus
            nxt   = S_IDLE;
          end else if (bstrb_i && level == LW'(1)) begin
            hold_set = 1'b1;         // write stall
            nxt      = S_IDLE;
          end
        end else begin
          push = bstrb_i;
          if (bstrb_i && bcnt == LW'(1)) begin
            hold_set = cur_rem > DEPTH_C;  // read stall
            nxt      = S_DRAIN;
          end
        end
      end
      S_DRAIN: begin
        pop = tack_i;
        if (tack_i && (cur_rem == CW'(1) || level == LW'(1))) nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= S_IDLE;
      cur    <= 1'b1;
      hold   <= 1'b0;
      bcnt   <= '0;
      teop_q <= 1'b0;
    end else begin
      st     <= nxt;
      teop_q <= fin;
      if (pick_en) cur <= pick;
      if (fin)           hold <= 1'b0;
      else if (hold_set) hold <= 1'b1;
      if (st == S_REQ && bgnt_i)
        bcnt <= (cur_rem > DEPTH_C) ? LW'(DEPTH) : cur_rem[LW-1:0];
      else if (push && st == S_BURST)
        bcnt <= bcnt - 1'b1;
    end
  end

  assign trq_o        = (st == S_FILL) || (st == S_DRAIN);
  assign breq_o       = (st == S_REQ) || (st == S_BURST) || hold;
  assign bstart_o     = (st == S_REQ) && bgnt_i;
  assign bburst_o     = (st == S_BURST);
  assign teop_o       = teop_q;
  assign tdat_o       = head;
  assign bdat_o       = head;
  assign cur_ch_o     = cur;
  assign fifo_level_o = level;
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          trq_o,
  input logic          breq_o,
  input logic          bstart_o,
  input logic          bburst_o,
  input logic          teop_o,
  input logic          cur_wr,
  input logic [LW-1:0] fifo_level_o
);
  a_r3_burst_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bstart_o |=> bburst_o);
  a_r4_teop_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    teop_o |=> !teop_o);
  a_r2_no_trq_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bburst_o |-> !trq_o);
  a_r7_req_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bburst_o |-> breq_o);
  a_r5_read_start_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bstart_o && !cur_wr) |-> (fifo_level_o == '0));
  a_r2_write_start_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bstart_o && cur_wr) |-> (fifo_level_o == LW'(DEPTH)));
  a_r12_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_level_o <= LW'(DEPTH));
endmodule

bind dma_seq_top dma_seq_chk #(.DEPTH(DEPTH), .LW(LW)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .trq_o        (trq_o),
  .breq_o       (breq_o),
  .bstart_o     (bstart_o),
  .bburst_o     (bburst_o),
  .teop_o       (teop_o),
  .cur_wr       (cur_wr),
  .fifo_level_o (fifo_level_o)
);

// File: tb/test_dma_seq_top.sv
`timescale 1ns/1ps
module test_dma_seq_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_valid_i = 1'b0, ld_chan_i = 1'b0, ld_wr_i = 1'b0;
  logic [15:0] ld_words_i = '0;
  logic [1:0]  done_clr_i = '0;
  logic        trq_o, tack_i = 1'b0, teop_o;
  logic [31:0] tdat_i = '0, tdat_o, bdat_i = '0, bdat_o;
  logic        breq_o, bgnt_i = 1'b0, bstart_o, bburst_o, bstrb_i = 1'b0;
  logic        obst_i = 1'b0, cur_ch_o;
  logic [1:0]  done_o;
  logic [3:0]  fifo_level_o;
  int n_chk = 0, n_err = 0;

  always #10 clk_i = ~clk_i;

  dma_seq_top i_dma_seq_top (.*);

  task automatic tick;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic ch, input logic wr, input int words);
    ld_valid_i = 1'b1; ld_chan_i = ch; ld_wr_i = wr; ld_words_i = 16'(words);
    tick();
    ld_valid_i = 1'b0;
  endtask

  task automatic local_push(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      tdat_i = base + 32'(i); tack_i = 1'b1;
      tick();
    end
    tack_i = 1'b0;
  endtask

  task automatic local_pop(input int n, input logic [31:0] base, input string tag);
    for (int i = 0; i < n; i++) begin
      chk({tag, " local data"}, tdat_o, base + 32'(i));
      tack_i = 1'b1;
      tick();
    end
    tack_i = 1'b0;
  endtask

  task automatic bus_push(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      bdat_i = base + 32'(i); bstrb_i = 1'b1;
      tick();
    end
    bstrb_i = 1'b0;
  endtask

  task automatic bus_pop(input int n, input logic [31:0] base, input string tag);
    for (int i = 0; i < n; i++) begin
      chk({tag, " bus data"}, bdat_o, base + 32'(i));
      bstrb_i = 1'b1;
      tick();
    end
    bstrb_i = 1'b0;
  endtask

  task automatic clear_done;
    done_clr_i = 2'b11;
    tick();
    done_clr_i = 2'b00;
  endtask

  task automatic t_reset;
    chk("R1 trq", trq_o, 0);
    chk("R1 breq", breq_o, 0);
    chk("R1 bstart/bburst", {bstart_o, bburst_o}, 0);
    chk("R1 teop", teop_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 level", fifo_level_o, 0);
  endtask

  task automatic t_write_short;
    load(0, 1, 5);
    load(0, 0, 20);                        // R10: busy channel, ignored
    chk("R2 trq while filling", trq_o, 1);
    chk("R2 no bus request yet", breq_o, 0);
    local_push(7, 32'h100);
    chk("R2 trq before full", trq_o, 1);
    chk("R2 level 7", fifo_level_o, 7);
    local_push(1, 32'h107);
    chk("R2 trq drops at full", trq_o, 0);
    chk("R3 breq while waiting", breq_o, 1);
    chk("R3 no start without grant", bstart_o, 0);
    tick();
    chk("R3 still waiting", {breq_o, bstart_o, bburst_o}, 3'b100);
    bgnt_i = 1'b1;
    #1 chk("R3 start with grant", bstart_o, 1);
    tick();
    chk("R3 burst after start", {bburst_o, bstart_o}, 2'b10);
    bus_pop(4, 32'h100, "R12");
    chk("R4 no early teop", teop_o, 0);
    bus_pop(1, 32'h104, "R12");
    chk("R4 teop after last", teop_o, 1);
    chk("R4 done ch0", done_o, 2'b01);
    chk("R4 surplus flushed", fifo_level_o, 0);
    chk("R10 busy load ignored, bus idle", {breq_o, bburst_o, trq_o}, 0);
    tick();
    chk("R4 teop one cycle", teop_o, 0);
    chk("R10 no follow-on transfer", {trq_o, breq_o}, 0);
    done_clr_i = 2'b01;
    tick();
    done_clr_i = 2'b00;
    chk("R11 done cleared", done_o, 0);
  endtask

  task automatic t_read_short;
    load(1, 0, 3);
    tick();
    chk("R5 read requests bus", {breq_o, trq_o}, 2'b10);
    chk("R5 start with empty fifo", {bstart_o, fifo_level_o}, {1'b1, 4'd0});
    tick();
    chk("R5 burst", bburst_o, 1);
    bus_push(3, 32'hA0);
    chk("R5 burst ends", bburst_o, 0);
    chk("R5 local request", trq_o, 1);
    chk("R5 level 3", fifo_level_o, 3);
    local_pop(3, 32'hA0, "R12");
    chk("R4 read teop", teop_o, 1);
    chk("R4 done ch1", done_o, 2'b10);
    clear_done();
  endtask

  task automatic t_read_stall;
    load(1, 0, 10);
    tick();
    tick();
    bus_push(8, 32'hB0);
    chk("R6 burst dropped", bburst_o, 0);
    chk("R6 breq held", breq_o, 1);
    chk("R6 trq up", trq_o, 1);
    chk("R6 fifo full", fifo_level_o, 8);
    local_pop(7, 32'hB0, "R6");
    chk("R6 trq until empty", trq_o, 1);
    local_pop(1, 32'hB7, "R6");
    chk("R6 trq off when empty", trq_o, 0);
    chk("R6 breq still held", breq_o, 1);
    tick();
    chk("R6 restart", {bstart_o, fifo_level_o}, {1'b1, 4'd0});
    tick();
    bus_push(2, 32'hB8);
    chk("R6 tail in fifo", fifo_level_o, 2);
    local_pop(2, 32'hB8, "R6");
    chk("R6 teop", teop_o, 1);
    chk("R6 breq released", breq_o, 0);
    clear_done();
  endtask

  task automatic t_alternate;
    load(0, 1, 12);
    load(1, 0, 3);
    local_push(8, 32'h200);
    chk("R7 start when full", bstart_o, 1);
    tick();
    bus_pop(8, 32'h200, "R12");
    chk("R7 burst dropped", bburst_o, 0);
    chk("R7 breq held", breq_o, 1);
    chk("R7 no start", bstart_o, 0);
    chk("R7 fifo empty", fifo_level_o, 0);
    tick();
    chk("R8 switched to ch1", cur_ch_o, 1);
    chk("R8 breq held", breq_o, 1);
    tick();
    bus_push(3, 32'hE0);
    local_pop(3, 32'hE0, "R8");
    chk("R8 ch1 done", done_o, 2'b10);
    tick();
    chk("R8 back to ch0", cur_ch_o, 0);
    chk("R7 refill", trq_o, 1);
    local_push(8, 32'h208);
    chk("R7 start only when full", {bstart_o, fifo_level_o}, {1'b1, 4'd8});
    tick();
    bus_pop(4, 32'h208, "R12");
    chk("R4 teop after prefetch", teop_o, 1);
    chk("R4 prefetch surplus gone", fifo_level_o, 0);
    chk("R4 both done", done_o, 2'b11);
    clear_done();
  endtask

  task automatic t_obstacle;
    load(0, 0, 4);
    tick();
    load(1, 0, 1);
    chk("R9 in burst", bburst_o, 1);
    bus_push(2, 32'hC0);
    obst_i = 1'b1;
    tick();
    obst_i = 1'b0;
    chk("R9 burst ended", bburst_o, 0);
    chk("R9 fifo flushed", fifo_level_o, 0);
    chk("R9 breq held", breq_o, 1);
    tick();
    chk("R8 other channel after obstacle", cur_ch_o, 1);
    tick();
    bus_push(1, 32'hF0);
    local_pop(1, 32'hF0, "R8");
    chk("R8 ch1 done", done_o, 2'b10);
    tick();
    chk("R9 ch0 resumes", cur_ch_o, 0);
    tick();
    bus_push(4, 32'hD0);
    chk("R9 count kept", fifo_level_o, 4);
    local_pop(3, 32'hD0, "R9");
    chk("R9 not finished early", teop_o, 0);
    local_pop(1, 32'hD3, "R9");
    chk("R9 teop", teop_o, 1);
    chk("R9 done", done_o, 2'b11);
    clear_done();
  endtask

  task automatic t_zero_len;
    load(1, 1, 0);
    tick();
    chk("R10 zero length ignored", {trq_o, breq_o, fifo_level_o}, 0);
    tick();
    chk("R10 zero length no done", done_o, 0);
  endtask

  initial begin
    fork
      begin
        @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        tick();
        t_write_short();
        t_read_short();
        t_read_stall();
        t_alternate();
        t_obstacle();
        t_zero_len();
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule